// File: doc/BRIEF.md
# Pointer-Register Address Generation Unit

This block forms data-memory addresses for the load, store, push and pop operations of a small 8-bit processor. The processor keeps three 16-bit pointer registers (called X, Y and Z here) in its register file. For each operation the register file presents the selected pointer's current value on `ptr_val`, and the block returns the memory address, a read or write strobe, and, where the mode changes the pointer, a write-back request carrying the new pointer value. The stack pointer is held inside the block.

An operation is requested with a one-cycle `start` pulse while the unit is idle. The mode, pointer select, displacement, direct address and pointer value are captured on that edge. The unit is then busy for exactly two cycles. In post-increment mode the memory access happens first and the pointer update follows. In pre-decrement mode the pointer update comes first and the access at the decremented address follows. A displacement request naming X, a pointer mode naming no pointer, or the reserved mode code is flagged as illegal and performs no access at all.

Top module: `ptr_agu`

## Requirements
- R1: After reset the unit is idle: `busy`, `mem_rd`, `mem_wr`, `ptr_we` and `mode_err` are 0, and the stack pointer holds SP_RESET (default 0x00DF), which is the address of the first push.
- R2: Mode 0 (plain indirect) accesses the address equal to the captured pointer value in the first busy cycle, as a write when `op_store`=1 and as a read otherwise, with no pointer write-back. Pointer codes are 0=X, 1=Y, 2=Z, 3=none.
- R3: Mode 1 (post-increment) accesses at the captured pointer in the first busy cycle, then in the second busy cycle raises `ptr_we` with `ptr_wsel` equal to the selected pointer and `ptr_wb` equal to pointer+1 modulo 2^16.
- R4: Mode 2 (pre-decrement) raises `ptr_we` with `ptr_wb` = pointer−1 modulo 2^16 in the first busy cycle, then accesses at that decremented address in the second busy cycle.
- R5: Mode 3 (displacement) with Y or Z accesses pointer + `disp_q` in the first busy cycle. `disp_q` is a 6-bit unsigned value that is zero-extended, and the sum wraps modulo 2^16. There is no write-back.
- R6: Mode 3 with X, modes 0–3 with pointer code 3, and mode 7 pulse `mode_err` in the first busy cycle and produce no strobe and no write-back in either busy cycle.
- R7: Mode 4 (direct) accesses address `direct_k` in the first busy cycle, with no write-back.
- R8: Mode 5 (push) writes at the current stack pointer in the first busy cycle, and the stack pointer is then reduced by one. `op_store` is ignored.
- R9: Mode 6 (pop) increases the stack pointer by one first, then reads at the new stack pointer in the second busy cycle. `op_store` is ignored.
- R10: An accepted start makes `busy` high for exactly two cycles. A start seen while busy is ignored.
- R11: `mem_rd` and `mem_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken only while idle |
| op_mode | input | 3 | Addressing mode code (0..7) |
| op_store | input | 1 | 1 = store, 0 = load (modes 0–4) |
| ptr_sel | input | 2 | Pointer select: 0=X, 1=Y, 2=Z, 3=none |
| disp_q | input | 6 | Unsigned displacement |
| direct_k | input | 16 | Direct address constant |
| ptr_val | input | 16 | Current value of the selected pointer |
| busy | output | 1 | Operation in progress |
| mem_addr | output | 16 | Data-memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ptr_we | output | 1 | Pointer write-back enable |
| ptr_wsel | output | 2 | Pointer written back |
| ptr_wb | output | 16 | New pointer value |
| mode_err | output | 1 | Illegal request flag |

## Verification
The bench pushes the wrap points hard: post-increment from 0xFFFF, pre-decrement from 0x0000, and the largest displacement added to a pointer near the top of memory. A design that carried into a seventeenth bit, or that sign-extended the displacement, would show a wrong address or write-back value. It compares the cycle in which the strobe and the write-back appear for the two update modes, so swapping the pre-decrement and post-increment ordering would put the strobe or `ptr_we` one cycle off. It runs push/pop sequences so that an off-by-one around the stack pointer's update order gives pop addresses that do not match the earlier pushes. It also checks that illegal requests and starts held high during a busy window cause no stray access.

// File: rtl/agu_pkg.sv
package agu_pkg;

    parameter int AGU_AW = 16;
    parameter int AGU_QW = 6;

    localparam logic [AGU_AW-1:0] AGU_ONE = {{(AGU_AW-1){1'b0}}, 1'b1};

    typedef enum logic [2:0] {
        AM_PLAIN   = 3'd0,
        AM_POSTINC = 3'd1,
        AM_PREDEC  = 3'd2,
        AM_DISP    = 3'd3,
        AM_DIRECT  = 3'd4,
        AM_PUSH    = 3'd5,
        AM_POP     = 3'd6,
        AM_RSVD    = 3'd7
    } agu_mode_e;

    typedef enum logic [1:0] {
        PTR_X    = 2'd0,
        PTR_Y    = 2'd1,
        PTR_Z    = 2'd2,
        PTR_NONE = 2'd3
    } ptr_id_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FIRST  = 2'd1,
        PH_SECOND = 2'd2
    } agu_phase_e;

    typedef struct packed {
        agu_mode_e         mode;
        logic              store;
        ptr_id_e           sel;
        logic [AGU_QW-1:0] q;
        logic [AGU_AW-1:0] k;
        logic [AGU_AW-1:0] p;
    } agu_req_t;

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [AGU_AW-1:0] addr;
        logic              we;
        ptr_id_e           wsel;
        logic [AGU_AW-1:0] wb;
        logic              ill;
    } agu_out_t;

    function automatic logic req_illegal(agu_req_t r);
        logic bad;
        case (r.mode)
            AM_DISP:                        bad = (r.sel == PTR_X) || (r.sel == PTR_NONE);
            AM_PLAIN, AM_POSTINC, AM_PREDEC: bad = (r.sel == PTR_NONE);
            AM_RSVD:                        bad = 1'b1;
            default:                        bad = 1'b0;
        endcase
        return bad;
    endfunction

    function automatic logic [AGU_AW-1:0] zext_q(logic [AGU_QW-1:0] q);
        return {{(AGU_AW-AGU_QW){1'b0}}, q};
    endfunction

endpackage

// File: rtl/agu_seq.sv
module agu_seq
    import agu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  agu_req_t   req_in,
    output agu_phase_e phase,
    output agu_req_t   req_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            req_q <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_FIRST;
                        req_q <= req_in;
                    end
                end
                PH_FIRST: phase <= PH_SECOND;
                default:  phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/agu_sp.sv
module agu_sp #(
    parameter int                AW   = 16,
    parameter logic [AW-1:0]     INIT = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    input  logic          dec,
    output logic [AW-1:0] sp
);

    localparam logic [AW-1:0] STEP = {{(AW-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst)
            sp <= INIT;
        else if (inc)
            sp <= sp + STEP;
        else if (dec)
            sp <= sp - STEP;
    end

endmodule

// File: rtl/agu_addr.sv
module agu_addr
    import agu_pkg::*;
(
    input  agu_phase_e        phase,
    input  agu_req_t          req,
    input  logic [AGU_AW-1:0] sp,
    output agu_out_t          o
);

    logic bad;

    always_comb begin
        bad = req_illegal(req);
        o   = '0;
        if (phase == PH_FIRST) begin
            o.ill = bad;
            if (!bad) begin
                case (req.mode)
                    AM_PLAIN, AM_POSTINC: begin
                        o.addr = req.p;
                        o.rd   = !req.store;
                        o.wr   = req.store;
                    end
                    AM_DISP: begin
                        o.addr = req.p + zext_q(req.q);
                        o.rd   = !req.store;
                        o.wr   = req.store;
                    end
                    AM_DIRECT: begin
                        o.addr = req.k;
                        o.rd   = !req.store;
                        o.wr   = req.store;
                    end
                    AM_PREDEC: begin
                        o.we   = 1'b1;
                        o.wsel = req.sel;
                        o.wb   = req.p - AGU_ONE;
                    end
                    AM_PUSH: begin
                        o.addr = sp;
                        o.wr   = 1'b1;
                    end
                    default: ;
                endcase
            end
        end else if (phase == PH_SECOND && !bad) begin
            case (req.mode)
                AM_POSTINC: begin
                    o.we   = 1'b1;
                    o.wsel = req.sel;
                    o.wb   = req.p + AGU_ONE;
                end
                AM_PREDEC: begin
                    o.addr = req.p - AGU_ONE;
                    o.rd   = !req.store;
                    o.wr   = req.store;
                end
                AM_POP: begin
                    o.addr = sp;
                    o.rd   = 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ptr_agu.sv
module ptr_agu
    import agu_pkg::*;
#(
    parameter logic [AGU_AW-1:0] SP_RESET = 16'h00DF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        op_mode,
    input  logic              op_store,
    input  logic [1:0]        ptr_sel,
    input  logic [AGU_QW-1:0] disp_q,
    input  logic [AGU_AW-1:0] direct_k,
    input  logic [AGU_AW-1:0] ptr_val,
    output logic              busy,
    output logic [AGU_AW-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              ptr_we,
    output logic [1:0]        ptr_wsel,
    output logic [AGU_AW-1:0] ptr_wb,
    output logic              mode_err
);

    agu_req_t          req_in;
    agu_req_t          req_q;
    agu_phase_e        phase;
    agu_out_t          res;
    logic [AGU_AW-1:0] sp_q;
    logic              sp_inc;
    logic              sp_dec;

    always_comb begin
        req_in.mode  = agu_mode_e'(op_mode);
        req_in.store = op_store;
        req_in.sel   = ptr_id_e'(ptr_sel);
        req_in.q     = disp_q;
        req_in.k     = direct_k;
        req_in.p     = ptr_val;
    end

    agu_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .req_in (req_in),
        .phase  (phase),
        .req_q  (req_q)
    );

    assign sp_inc = (phase == PH_FIRST)  && (req_q.mode == AM_POP);
    assign sp_dec = (phase == PH_SECOND) && (req_q.mode == AM_PUSH);

    agu_sp #(
        .AW   (AGU_AW),
        .INIT (SP_RESET)
    ) u_sp (
        .clk (clk),
        .rst (rst),
        .inc (sp_inc),
        .dec (sp_dec),
        .sp  (sp_q)
    );

    agu_addr u_addr (
        .phase (phase),
        .req   (req_q),
        .sp    (sp_q),
        .o     (res)
    );

    assign busy     = (phase != PH_IDLE);
    assign mem_addr = res.addr;
    assign mem_rd   = res.rd;
    assign mem_wr   = res.wr;
    assign ptr_we   = res.we;
    assign ptr_wsel = res.wsel;
    assign ptr_wb   = res.wb;
    assign mode_err = res.ill;

endmodule

// File: rtl/agu_checker.sv
module agu_checker
    import agu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              ptr_we,
    input logic [1:0]        ptr_wsel,
    input logic [AGU_AW-1:0] mem_addr,
    input logic [AGU_AW-1:0] ptr_wb,
    input logic [AGU_AW-1:0] sp_q,
    input logic              mode_err,
    input agu_phase_e        phase,
    input agu_mode_e         cur_mode
);

    assert_one_strobe_R11: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    assert_illegal_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        mode_err |-> (!mem_rd && !mem_wr && !ptr_we));

    assert_illegal_no_followup_R6: assert property (@(posedge clk) disable iff (rst)
        mode_err |=> (!mem_rd && !mem_wr && !ptr_we));

    assert_busy_enter_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && !$past(busy)) |=> busy);

    assert_busy_leave_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |=> !busy);

    assert_wb_target_R3: assert property (@(posedge clk) disable iff (rst)
        ptr_we |-> (ptr_wsel != 2'd3));

    assert_postinc_order_R3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FIRST && cur_mode == AM_POSTINC && (mem_rd || mem_wr))
        |=> (ptr_we && !mem_rd && !mem_wr));

    assert_predec_order_R4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FIRST && cur_mode == AM_PREDEC && ptr_we)
        |=> ((mem_rd || mem_wr) && mem_addr == $past(ptr_wb)));

    assert_push_dec_R8: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SECOND && cur_mode == AM_PUSH)
        |=> (sp_q == $past(sp_q) - AGU_ONE));

    assert_pop_inc_R9: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FIRST && cur_mode == AM_POP)
        |=> (sp_q == $past(sp_q) + AGU_ONE));

endmodule

bind ptr_agu agu_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .ptr_we   (ptr_we),
    .ptr_wsel (ptr_wsel),
    .mem_addr (mem_addr),
    .ptr_wb   (ptr_wb),
    .sp_q     (sp_q),
    .mode_err (mode_err),
    .phase    (phase),
    .cur_mode (req_q.mode)
);

// File: tb/sim_ptr_agu.sv
module sim_ptr_agu;

    localparam logic [15:0] SPR = 16'h00DF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  op_mode = '0;
    logic        op_store = 1'b0;
    logic [1:0]  ptr_sel = '0;
    logic [5:0]  disp_q = '0;
    logic [15:0] direct_k = '0;
    logic [15:0] ptr_val = '0;
    logic        busy, mem_rd, mem_wr, ptr_we, mode_err;
    logic [15:0] mem_addr, ptr_wb;
    logic [1:0]  ptr_wsel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ptr_agu #(.SP_RESET(SPR)) u0 (
        .clk(clk), .rst(rst), .start(start), .op_mode(op_mode), .op_store(op_store),
        .ptr_sel(ptr_sel), .disp_q(disp_q), .direct_k(direct_k), .ptr_val(ptr_val),
        .busy(busy), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .ptr_we(ptr_we), .ptr_wsel(ptr_wsel), .ptr_wb(ptr_wb), .mode_err(mode_err)
    );

    // behavioural reference state
    int          mph = 0;
    int          mm = 0;
    bit          mst = 0;
    int          msel = 0;
    logic [15:0] mq = 0, mk = 0, mp = 0, msp = SPR;

    function automatic bit bad_req(int m, int s);
        if (m == 7) return 1;
        if (m == 3) return (s == 0 || s == 3);
        if (m <= 2) return (s == 3);
        return 0;
    endfunction

    function automatic string tag_of(int m, int s);
        if (bad_req(m, s)) return "R6";
        case (m)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R7";
            5: return "R8";
            default: return "R9";
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mph = 0;
            msp = SPR;
        end else begin
            case (mph)
                0: if (start) begin
                    mm = int'(op_mode); mst = op_store; msel = int'(ptr_sel);
                    mq = {10'd0, disp_q}; mk = direct_k; mp = ptr_val; mph = 1;
                end
                1: begin
                    if (mm == 6) msp = msp + 16'd1;
                    mph = 2;
                end
                default: begin
                    if (mm == 5) msp = msp - 16'd1;
                    mph = 0;
                end
            endcase
        end
    end

    task automatic chk(bit ok, string req, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            bit e_rd, e_wr, e_we, e_ill, bad;
            logic [15:0] e_addr, e_wb;
            string t;
            e_rd = 0; e_wr = 0; e_we = 0; e_ill = 0; e_addr = 0; e_wb = 0;
            bad = bad_req(mm, msel);
            t = tag_of(mm, msel);
            if (mph == 1) begin
                e_ill = bad;
                if (!bad) begin
                    case (mm)
                        0, 1: begin e_addr = mp; e_rd = !mst; e_wr = mst; end
                        3: begin e_addr = mp + mq; e_rd = !mst; e_wr = mst; end
                        4: begin e_addr = mk; e_rd = !mst; e_wr = mst; end
                        2: begin e_we = 1; e_wb = mp - 16'd1; end
                        5: begin e_addr = msp; e_wr = 1; end
                        default: ;
                    endcase
                end
            end else if (mph == 2 && !bad) begin
                case (mm)
                    1: begin e_we = 1; e_wb = mp + 16'd1; end
                    2: begin e_addr = mp - 16'd1; e_rd = !mst; e_wr = mst; end
                    6: begin e_addr = msp; e_rd = 1; end
                    default: ;
                endcase
            end
            chk(busy == (mph != 0), "R10", "busy", {15'd0, busy}, {15'd0, mph != 0});
            chk(!(mem_rd && mem_wr), "R11", "rd/wr together", {15'd0, mem_rd}, {15'd0, mem_wr});
            chk(mem_rd == e_rd, t, "mem_rd", {15'd0, mem_rd}, {15'd0, e_rd});
            chk(mem_wr == e_wr, t, "mem_wr", {15'd0, mem_wr}, {15'd0, e_wr});
            chk(mode_err == e_ill, "R6", "mode_err", {15'd0, mode_err}, {15'd0, e_ill});
            chk(ptr_we == e_we, t, "ptr_we", {15'd0, ptr_we}, {15'd0, e_we});
            if (e_rd || e_wr)
                chk(mem_addr == e_addr, t, "mem_addr", mem_addr, e_addr);
            if (e_we) begin
                chk(ptr_wb == e_wb, t, "ptr_wb", ptr_wb, e_wb);
                chk(int'(ptr_wsel) == msel, t, "ptr_wsel", {14'd0, ptr_wsel}, msel[15:0]);
            end
        end
    end

    task automatic op(int m, bit st, int s, int q, logic [15:0] k, logic [15:0] p);
        op_mode = m[2:0]; op_store = st; ptr_sel = s[1:0];
        disp_q = q[5:0]; direct_k = k; ptr_val = p; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle outputs after reset
        chk(!busy && !mem_rd && !mem_wr && !ptr_we && !mode_err, "R1", "idle after reset",
            {11'd0, busy, mem_rd, mem_wr, ptr_we, mode_err}, 16'd0);
        // R1: first push lands at the reset stack pointer
        op_mode = 3'd5; ptr_val = 16'h0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(mem_wr && mem_addr == SPR, "R1", "first push address", mem_addr, SPR);
        @(negedge clk); @(negedge clk);

        op(0, 0, 0, 0, 16'h0, 16'h1234);     // R2 load X
        op(0, 1, 2, 0, 16'h0, 16'h8001);     // R2 store Z
        op(1, 0, 1, 0, 16'h0, 16'hFFFF);     // R3 wrap to 0000
        op(1, 1, 0, 0, 16'h0, 16'h00A0);     // R3 store X
        op(2, 0, 2, 0, 16'h0, 16'h0000);     // R4 wrap to FFFF
        op(2, 1, 1, 0, 16'h0, 16'h0100);     // R4 store Y
        op(3, 0, 1, 63, 16'h0, 16'hFFF0);    // R5 wraps to 002F
        op(3, 1, 2, 0, 16'h0, 16'h0400);     // R5 zero displacement
        op(3, 0, 2, 32, 16'h0, 16'h1000);    // R5 upper bit of q, no sign extension
        op(3, 1, 0, 5, 16'h0, 16'h2000);     // R6 displacement with X
        op(1, 0, 3, 0, 16'h0, 16'h2000);     // R6 no pointer
        op(7, 1, 1, 0, 16'h0, 16'h2000);     // R6 reserved mode
        op(4, 0, 0, 0, 16'hABCD, 16'h0);     // R7 load
        op(4, 1, 3, 0, 16'hFFFF, 16'h0);     // R7 store, pointer select unused
        op(5, 0, 0, 0, 16'h0, 16'h0);        // R8
        op(5, 0, 0, 0, 16'h0, 16'h0);        // R8
        op(6, 1, 0, 0, 16'h0, 16'h0);        // R9 store flag ignored
        op(6, 0, 0, 0, 16'h0, 16'h0);        // R9
        op(6, 0, 0, 0, 16'h0, 16'h0);        // R9

        // R10: start held high through the busy window is not re-accepted
        op_mode = 3'd0; op_store = 1'b0; ptr_sel = 2'd1; ptr_val = 16'h5555; start = 1'b1;
        @(negedge clk);
        op_mode = 3'd4; direct_k = 16'h7777;
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        chk(!busy, "R10", "busy after two cycles with start held", {15'd0, busy}, 16'd0);
        @(negedge clk); @(negedge clk); @(negedge clk);

        for (int i = 0; i < 300; i++) begin
            op($urandom_range(0, 7), 1'($urandom_range(0, 1)), $urandom_range(0, 3),
               $urandom_range(0, 63), 16'($urandom), 16'($urandom));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule